// File: doc/BRIEF.md
# External Interrupt Sense Controller

This block turns activity on two external interrupt pins and on a sixteen-input pin-change group into interrupt requests for a processor core. Each external pin has its own 2-bit sense field. The field picks one of four modes: low level, any change, falling edge or rising edge. The pin-change group is filtered by a 16-bit mask and produces one shared request when any enabled input toggles. All inputs pass through a two-flop synchronizer, and edges are found by comparing the synchronized value with the sample from the previous clock.

Edge, any-change and pin-change events are held in a small two-state flag machine per source. The states are `FLG_IDLE` and `FLG_PEND`. The transition `FLG_IDLE -> FLG_PEND` happens on a detected event. The transition `FLG_PEND -> FLG_IDLE` happens on a clear when no new event arrives in the same cycle. A clear is either an acknowledge pulse or a write of 1 to the flag bit. Low-level mode keeps no flag and follows the synchronized pin directly. A request reaches the core only when the global interrupt enable and the source's own enable bit are both set.

A wake output works without the clock. It is driven from the raw pins for an enabled low-level source and for enabled, unmasked pin-change differences. It also stays high while a pin-change flag is pending. Pins that are driven as outputs trigger the same way as inputs, so firmware can raise software interrupts by writing to them.

Top module: `ext_irq_sense`

## Requirements
- R1: The control register is at address 0. Sense field of external pin i is at bits [2i+1:2i], with 00 = low level, 01 = any change, 10 = falling edge and 11 = rising edge. Bit 4 enables pin 0, bit 5 enables pin 1 and bit 6 enables the pin-change group. Reads of address 0 return the written value.
- R2: In edge and any-change modes, a matching transition of the pin sets a sticky flag. The request appears three clock edges after the pin changes and stays set after the pin returns, until it is cleared. A transition that does not match the mode sets nothing.
- R3: A pulse of one full clock period on a pin in an edge mode produces a request.
- R4: In low-level mode the request is high two clock edges after the pin goes low. It stays high while the pin is low and drops two edges after release, leaving no flag.
- R5: The mask register is at address 1. A toggle on any input whose mask bit is 1 sets the shared pin-change request (irq_req bit 2) three edges later. A toggle on an input whose mask bit is 0 sets nothing, and several inputs toggling together give one request.
- R6: irq_req bit i is high only when global_ie and the source's enable bit are both set. A flag latched while global_ie is low stays readable at address 2 and raises the request as soon as global_ie returns.
- R7: A flag clears on the edge of a one-cycle ack pulse for its source, or on a write to address 2 with a 1 in its bit (bit 0 = pin 0, bit 1 = pin 1, bit 2 = pin-change).
- R8: After reset all registers read zero, both pins are in low-level mode with enables off, and irq_req and wake are low.
- R9: Writing the control register never creates an event in the cycle of the write. Switching a pin held low from low-level mode to falling-edge mode raises no request.
- R10: wake is high without any clock edge when an enabled low-level pin is low, or when an enabled group input with a set mask bit differs from its last sample. It also stays high while the pin-change flag is pending. Edge modes never drive wake.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | I/O clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ext_pin | input | 2 | External interrupt pins |
| pc_pin | input | 16 | Pin-change group inputs |
| global_ie | input | 1 | Global interrupt enable from the core |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Register write address |
| wr_data | input | 16 | Register write data |
| rd_addr | input | 2 | Register read address |
| rd_data | output | 16 | Register read data (combinational) |
| ack | input | 3 | Per-source acknowledge pulses |
| irq_req | output | 3 | Gated requests: pin 0, pin 1, pin-change |
| wake | output | 1 | Clockless wake request |

## Verification
The hardest case to reach is a flag that must survive while its request is hidden. This happens when an event lands while global_ie or the source enable is low: the flag has to stay latched and readable, and only the gate releases it. The stimulus reaches this state by dropping global_ie, toggling a pin in any-change mode, and reading address 2 before raising global_ie again. The one-cycle pulse in rising-edge mode and the switch from low-level to falling-edge mode with the pin held low are placed so that the exact edge on which the synchronized value moves can be predicted.

// File: rtl/ext_irq_pkg.sv
package ext_irq_pkg;

    typedef enum logic [1:0] {
        SENSE_LOW  = 2'b00,
        SENSE_ANY  = 2'b01,
        SENSE_FALL = 2'b10,
        SENSE_RISE = 2'b11
    } sense_t;

    typedef enum logic {
        FLG_IDLE = 1'b0,
        FLG_PEND = 1'b1
    } flag_st_t;

    localparam logic [1:0] ADDR_CTRL = 2'd0;
    localparam logic [1:0] ADDR_MASK = 2'd1;
    localparam logic [1:0] ADDR_FLAG = 2'd2;

endpackage

// File: rtl/sync_cell.sv
module sync_cell #(
    parameter int W = 1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] meta_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            meta_q <= '0;
            q      <= '0;
        end else begin
            meta_q <= d;
            q      <= meta_q;
        end
    end
endmodule

// File: rtl/irq_flag_fsm.sv
module irq_flag_fsm
    import ext_irq_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic set,
    input  logic clr,
    output logic pend
);
    flag_st_t state_q, state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= FLG_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            FLG_IDLE: if (set)         state_d = FLG_PEND;
            FLG_PEND: if (clr && !set) state_d = FLG_IDLE;
        endcase
    end

    always_comb begin
        pend = (state_q == FLG_PEND);
    end

    // R2
    set_latch_chk: assert property (@(posedge clk) disable iff (!rst_n)
        set |=> pend);

    // R7
    pend_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pend && clr && !set) |=> !pend);
endmodule

// File: rtl/ext_sense.sv
module ext_sense
    import ext_irq_pkg::*;
(
    input  logic   clk,
    input  logic   rst_n,
    input  logic   pin_raw,
    input  logic   pin_s,
    input  sense_t mode,
    input  logic   mode_wr,
    input  logic   clr,
    output logic   active,
    output logic   wake_lvl
);
    logic prev_q;
    logic evt;
    logic pend;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) prev_q <= 1'b0;
        else        prev_q <= pin_s;
    end

    always_comb begin
        evt = 1'b0;
        unique case (mode)
            SENSE_LOW:  evt = 1'b0;
            SENSE_ANY:  evt = pin_s ^ prev_q;
            SENSE_FALL: evt = prev_q & ~pin_s;
            SENSE_RISE: evt = ~prev_q & pin_s;
        endcase
        if (mode_wr) evt = 1'b0;
    end

    irq_flag_fsm u_flag (
        .clk   (clk),
        .rst_n (rst_n),
        .set   (evt),
        .clr   (clr),
        .pend  (pend)
    );

    assign active   = (mode == SENSE_LOW) ? ~pin_s : pend;
    assign wake_lvl = (mode == SENSE_LOW) & ~pin_raw;

    // R9
    no_mode_wr_evt_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mode_wr |-> !evt);

    // R4
    level_no_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == SENSE_LOW) |-> !evt);
endmodule

// File: rtl/pc_detect.sv
module pc_detect #(
    parameter int N = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] pc_raw,
    input  logic [N-1:0] pc_s,
    input  logic [N-1:0] mask,
    input  logic         clr,
    output logic         pend,
    output logic         wake_pc
);
    logic [N-1:0] prev_q;
    logic         evt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) prev_q <= '0;
        else        prev_q <= pc_s;
    end

    assign evt     = |((pc_s ^ prev_q) & mask);
    assign wake_pc = (|((pc_raw ^ prev_q) & mask)) | pend;

    irq_flag_fsm u_flag (
        .clk   (clk),
        .rst_n (rst_n),
        .set   (evt),
        .clr   (clr),
        .pend  (pend)
    );

    // R5
    mask_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mask == '0) |-> !evt);
endmodule

// File: rtl/ext_irq_sense.sv
module ext_irq_sense
    import ext_irq_pkg::*;
#(
    parameter int N_EXT = 2,
    parameter int N_PC  = 16
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [N_EXT-1:0]        ext_pin,
    input  logic [N_PC-1:0]         pc_pin,
    input  logic                    global_ie,
    input  logic                    wr_en,
    input  logic [1:0]              wr_addr,
    input  logic [N_PC-1:0]         wr_data,
    input  logic [1:0]              rd_addr,
    output logic [N_PC-1:0]         rd_data,
    input  logic [N_EXT:0]          ack,
    output logic [N_EXT:0]          irq_req,
    output logic                    wake
);
    localparam int NSRC   = N_EXT + 1;
    localparam int CTRL_W = 3 * N_EXT + 1;
    localparam int EN_LO  = 2 * N_EXT;
    localparam int PC_EN  = 3 * N_EXT;

    logic [CTRL_W-1:0] ctrl_q;
    logic [N_PC-1:0]   mask_q;
    logic [N_EXT-1:0]  ext_s;
    logic [N_PC-1:0]   pc_s;
    logic [NSRC-1:0]   clr;
    logic [NSRC-1:0]   active;
    logic [NSRC-1:0]   enable;
    logic [N_EXT-1:0]  wake_lvl;
    logic              wake_pc;
    logic              ctrl_wr;

    assign ctrl_wr = wr_en && (wr_addr == ADDR_CTRL);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctrl_q <= '0;
            mask_q <= '0;
        end else if (wr_en) begin
            if (wr_addr == ADDR_CTRL) ctrl_q <= wr_data[CTRL_W-1:0];
            if (wr_addr == ADDR_MASK) mask_q <= wr_data;
        end
    end

    always_comb begin
        clr = ack;
        if (wr_en && (wr_addr == ADDR_FLAG)) clr = clr | wr_data[NSRC-1:0];
    end

    sync_cell #(.W(N_EXT)) u_sync_ext (.clk(clk), .rst_n(rst_n), .d(ext_pin), .q(ext_s));
    sync_cell #(.W(N_PC))  u_sync_pc  (.clk(clk), .rst_n(rst_n), .d(pc_pin),  .q(pc_s));

    for (genvar i = 0; i < N_EXT; i++) begin : g_ext
        ext_sense u_sense (
            .clk      (clk),
            .rst_n    (rst_n),
            .pin_raw  (ext_pin[i]),
            .pin_s    (ext_s[i]),
            .mode     (sense_t'(ctrl_q[2*i +: 2])),
            .mode_wr  (ctrl_wr),
            .clr      (clr[i]),
            .active   (active[i]),
            .wake_lvl (wake_lvl[i])
        );
        assign enable[i] = ctrl_q[EN_LO + i];
    end

    pc_detect #(.N(N_PC)) u_pc (
        .clk     (clk),
        .rst_n   (rst_n),
        .pc_raw  (pc_pin),
        .pc_s    (pc_s),
        .mask    (mask_q),
        .clr     (clr[N_EXT]),
        .pend    (active[N_EXT]),
        .wake_pc (wake_pc)
    );
    assign enable[N_EXT] = ctrl_q[PC_EN];

    assign irq_req = global_ie ? (active & enable) : '0;
    assign wake    = (|(wake_lvl & enable[N_EXT-1:0])) | (wake_pc & enable[N_EXT]);

    always_comb begin
        rd_data = '0;
        unique case (rd_addr)
            ADDR_CTRL: rd_data = N_PC'(ctrl_q);
            ADDR_MASK: rd_data = mask_q;
            ADDR_FLAG: rd_data = N_PC'(active);
            default:   rd_data = '0;
        endcase
    end

    // R6
    gate_ie_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_req != '0) |-> global_ie);

    // R6
    gate_en_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((irq_req & ~enable) == '0));
endmodule

// File: tb/tb_ext_irq_sense.sv
module tb_ext_irq_sense;
    logic        clk = 1'b0;
    logic        rst_n;
    logic [1:0]  ext_pin;
    logic [15:0] pc_pin;
    logic        global_ie;
    logic        wr_en;
    logic [1:0]  wr_addr;
    logic [15:0] wr_data;
    logic [1:0]  rd_addr;
    logic [15:0] rd_data;
    logic [2:0]  ack;
    logic [2:0]  irq_req;
    logic        wake;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 0;

    typedef struct {
        string       tag;
        int          kind;
        logic [15:0] exp;
    } item_t;

    item_t q[$];
    event  sample_ev;

    always #10 clk = ~clk;

    ext_irq_sense dut (
        .clk(clk), .rst_n(rst_n), .ext_pin(ext_pin), .pc_pin(pc_pin),
        .global_ie(global_ie), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data),
        .ack(ack), .irq_req(irq_req), .wake(wake)
    );

    initial begin
        forever begin
            @(sample_ev);
            while (q.size() > 0) begin
                item_t it;
                logic [15:0] act;
                it = q.pop_front();
                case (it.kind)
                    0:       act = {13'b0, irq_req};
                    1:       act = rd_data;
                    default: act = {15'b0, wake};
                endcase
                n_checks++;
                if (act !== it.exp) begin
                    n_fail++;
                    $display("FAIL %s: actual %h expected %h", it.tag, act, it.exp);
                end
            end
        end
    end

    task automatic tick(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr(logic [1:0] a, logic [15:0] d);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic expect_val(string tag, int kind, logic [15:0] exp);
        item_t it;
        it.tag = tag; it.kind = kind; it.exp = exp;
        q.push_back(it);
        ->sample_ev;
        #1;
    endtask

    task automatic pulse_ack(logic [2:0] a);
        ack = a;
        tick(1);
        ack = 3'b000;
    endtask

    initial begin
        rst_n = 1'b0; ext_pin = 2'b11; pc_pin = '0; global_ie = 1'b0;
        wr_en = 1'b0; wr_addr = '0; wr_data = '0; rd_addr = '0; ack = '0;
        tick(3);
        rst_n = 1'b1;
        tick(3);

        // R8 reset state
        expect_val("R8 irq after reset", 0, 16'h0000);
        expect_val("R8 wake after reset", 2, 16'h0000);
        rd_addr = 2'd0; expect_val("R8 ctrl reset", 1, 16'h0000);
        rd_addr = 2'd1; expect_val("R8 mask reset", 1, 16'h0000);
        rd_addr = 2'd2; expect_val("R8 flags reset", 1, 16'h0000);

        // R4 low-level mode on pin 0
        global_ie = 1'b1;
        wr(2'd0, 16'h0010);
        ext_pin[0] = 1'b0;
        expect_val("R10 wake on raw low level", 2, 16'h0001);
        tick(1); expect_val("R4 level not yet synced", 0, 16'h0000);
        tick(1); expect_val("R4 level request", 0, 16'h0001);
        tick(4); expect_val("R4 level held", 0, 16'h0001);
        ext_pin[0] = 1'b1;
        expect_val("R10 wake drops on release", 2, 16'h0000);
        tick(2); expect_val("R4 level released", 0, 16'h0000);
        rd_addr = 2'd2; expect_val("R4 no sticky flag", 1, 16'h0000);

        // R9 mode switch while pin held low
        ext_pin[0] = 1'b0;
        tick(3); expect_val("R9 level before switch", 0, 16'h0001);
        wr(2'd0, 16'h0012);
        expect_val("R9 no request after switch", 0, 16'h0000);
        tick(3); expect_val("R9 still no request", 0, 16'h0000);
        expect_val("R10 edge mode no wake", 2, 16'h0000);

        // R2 falling-edge mode
        ext_pin[0] = 1'b1;
        tick(4); expect_val("R2 rise ignored in fall mode", 0, 16'h0000);
        ext_pin[0] = 1'b0;
        tick(2); expect_val("R2 fall not yet flagged", 0, 16'h0000);
        tick(1); expect_val("R2 fall flagged", 0, 16'h0001);
        ext_pin[0] = 1'b1;
        tick(4); expect_val("R2 flag sticky", 0, 16'h0001);
        pulse_ack(3'b001);
        expect_val("R7 ack clears", 0, 16'h0000);

        // R3 single-cycle pulse, rising mode on pin 1
        wr(2'd0, 16'h003E);
        tick(2);
        ext_pin[1] = 1'b0;
        tick(1);
        ext_pin[1] = 1'b1;
        tick(2); expect_val("R3 rise not yet flagged", 0, 16'h0000);
        tick(1); expect_val("R3 short pulse flagged", 0, 16'h0002);
        wr(2'd2, 16'h0002);
        expect_val("R7 write-one clears", 0, 16'h0000);
        rd_addr = 2'd0; expect_val("R1 ctrl readback", 1, 16'h003E);

        // R2 any-change mode on pin 0
        wr(2'd0, 16'h003D);
        ext_pin[0] = 1'b0;
        tick(3); expect_val("R2 any-change fall", 0, 16'h0001);
        wr(2'd2, 16'h0001);
        ext_pin[0] = 1'b1;
        tick(3); expect_val("R2 any-change rise", 0, 16'h0001);
        pulse_ack(3'b001);

        // R6 gating
        global_ie = 1'b0;
        ext_pin[0] = 1'b0;
        tick(3); expect_val("R6 hidden by global enable", 0, 16'h0000);
        rd_addr = 2'd2; expect_val("R6 flag latched", 1, 16'h0001);
        global_ie = 1'b1;
        expect_val("R6 released by global enable", 0, 16'h0001);
        pulse_ack(3'b001);
        wr(2'd0, 16'h002D);
        ext_pin[0] = 1'b1;
        tick(3); expect_val("R6 hidden by source enable", 0, 16'h0000);
        expect_val("R6 flag latched disabled", 1, 16'h0001);
        wr(2'd2, 16'h0001);

        // R5 pin-change group
        wr(2'd0, 16'h006D);
        wr(2'd1, 16'h0010);
        rd_addr = 2'd1; expect_val("R5 mask readback", 1, 16'h0010);
        pc_pin = 16'h0008;
        expect_val("R10 masked toggle no wake", 2, 16'h0000);
        tick(4); expect_val("R5 masked toggle ignored", 0, 16'h0000);
        pc_pin = 16'h0018;
        expect_val("R10 wake on enabled toggle", 2, 16'h0001);
        tick(3); expect_val("R5 enabled toggle", 0, 16'h0004);
        tick(2); expect_val("R10 wake while pending", 2, 16'h0001);
        pulse_ack(3'b100);
        expect_val("R7 pin-change ack", 0, 16'h0000);
        expect_val("R10 wake cleared", 2, 16'h0000);
        wr(2'd1, 16'hFFFF);
        pc_pin = 16'h8019;
        tick(3); expect_val("R5 shared request", 0, 16'h0004);
        pulse_ack(3'b100);

        tick(2);
        done = 1'b1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        #(20 * 200000);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end
endmodule